// File: doc/BRIEF.md
# Supervisor Control Register Bank

This block keeps the small set of supervisor-level state registers that a processor core reads and writes with its privileged move instructions: a status word, the exception return address, the faulting virtual address, the exception vector base, a constant that reports installed memory in 4 KiB pages, and a pair of host mailbox words (one written by the core toward the host, one supplied by the host). Each access names a register by a 5-bit index. The register numbers are sparse and fixed. An index that has no register reads as all ones. A write to an index that has no writable register is dropped.

Every access is checked for privilege. An access outside supervisor mode, or a full-width access while the core is not in 64-bit mode, raises a fault flag and changes nothing. Word-width access works on the low 32 bits. The value read and the value written are both sign-extended from bit 31. The faulting-address register is not writable through the access port. It is loaded only by a separate trap-capture strobe from the core's exception logic. Reads and the fault flag are registered: both appear one cycle after the strobe.

Top module: `sup_ctrl_regs`

## Requirements
- R1: After reset, rdData, privFault and toHost are 0, and the status, return-address, fault-address and vector-base registers all read as 0.
- R2: A permitted read (rdEn=1) loads rdData on the next clock edge. Index 0 gives status, index 1 the exception return address, index 2 the faulting address, index 3 the vector base and index 17 the fromHost input.
- R3: A permitted read of index 8 returns MEM_BYTES shifted right by 12.
- R4: A permitted read of any index other than 0, 1, 2, 3, 8 and 17 returns all ones.
- R5: A permitted write (wrEn=1) updates status at index 0, the return address at index 1, the vector base at index 3 and toHost at index 16. A write to any other index, including 2 and 17, leaves all state unchanged.
- R6: The vector base always stores the written value with bits 11:0 forced to 0.
- R7: An access (rdEn or wrEn) with supMode=0 sets privFault on the next edge and changes no register or toHost. A faulted read loads rdData with 0. privFault is 0 after any cycle with a permitted access or with no access.
- R8: With wordMode=1, a read returns bits 31:0 of the selected value sign-extended from bit 31 to 64 bits.
- R9: With wordMode=1, a write stores bits 31:0 of wrData sign-extended from bit 31, before any masking of the vector base.
- R10: A full-width access (wordMode=0) with wide64Mode=0 faults exactly as in R7. A word access with wide64Mode=0 is permitted.
- R11: trapCapture=1 loads trapAddr, at full width, into the faulting-address register on the next edge, independent of privilege and mode inputs.
- R12: The toHost output always shows the stored to-host register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regIdx | input | 5 | Register index of the access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wordMode | input | 1 | 1 = 32-bit access with sign extension, 0 = full width |
| wide64Mode | input | 1 | Core is in 64-bit mode (needed for full-width access) |
| supMode | input | 1 | Core is in supervisor mode |
| wrData | input | 64 | Value to write |
| fromHost | input | 64 | Mailbox value supplied by the host |
| trapCapture | input | 1 | Loads the faulting-address register |
| trapAddr | input | 64 | Faulting virtual address to capture |
| rdData | output | 64 | Registered read result |
| privFault | output | 1 | Registered privilege/mode fault flag |
| toHost | output | 64 | Mailbox value written by the core |

## Verification
The assertions assume that regIdx, the mode inputs and the strobes are stable around the sampling edge. They also assume that no read and write to the same register occur in one cycle, because such a read would see the old value and the properties on readback would not apply. The bench drives every input on the falling edge, and each access lasts exactly one cycle. Each scenario issues reads and writes as separate accesses. This keeps the stimulus inside those assumptions while still covering faulted, word-width and full-width accesses against every mapped and several unmapped indices.

// File: rtl/sup_ctrl_regs_pkg.sv
package sup_ctrl_regs_pkg;

  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IDX_STATUS   = 5'd0;
  localparam logic [IDX_W-1:0] IDX_EPC      = 5'd1;
  localparam logic [IDX_W-1:0] IDX_BADVA    = 5'd2;
  localparam logic [IDX_W-1:0] IDX_EBASE    = 5'd3;
  localparam logic [IDX_W-1:0] IDX_MEMSZ    = 5'd8;
  localparam logic [IDX_W-1:0] IDX_TOHOST   = 5'd16;
  localparam logic [IDX_W-1:0] IDX_FROMHOST = 5'd17;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_EPC,
    SEL_BADVA,
    SEL_EBASE,
    SEL_MEMSZ,
    SEL_FROMHOST,
    SEL_NONE
  } rdSel_e;

  // Strobes from control to datapath for one access cycle
  typedef struct packed {
    logic   rdLoad;    // permitted read: load selected value
    logic   rdClear;   // faulted read: load zero
    logic   wrStatus;
    logic   wrEpc;
    logic   wrEbase;
    logic   wrToHost;
    logic   narrow;    // word-width access
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/sup_ctrl_regs_ctrl.sv
module sup_ctrl_regs_ctrl
  import sup_ctrl_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic             wordMode,
  input  logic             wide64Mode,
  input  logic             supMode,
  output strobes_t         strb,
  output logic             privFault
);

  logic permitted;
  logic anyAccess;
  logic goodWr;

  assign anyAccess = rdEn | wrEn;
  // Supervisor always needed; full width additionally needs 64-bit mode
  assign permitted = supMode & (wordMode | wide64Mode);
  assign goodWr    = wrEn & permitted;

  always_comb begin
    strb.rdLoad   = rdEn & permitted;
    strb.rdClear  = rdEn & ~permitted;
    strb.narrow   = wordMode;
    strb.wrStatus = goodWr & (regIdx == IDX_STATUS);
    strb.wrEpc    = goodWr & (regIdx == IDX_EPC);
    strb.wrEbase  = goodWr & (regIdx == IDX_EBASE);
    strb.wrToHost = goodWr & (regIdx == IDX_TOHOST);
    case (regIdx)
      IDX_STATUS:   strb.rdSel = SEL_STATUS;
      IDX_EPC:      strb.rdSel = SEL_EPC;
      IDX_BADVA:    strb.rdSel = SEL_BADVA;
      IDX_EBASE:    strb.rdSel = SEL_EBASE;
      IDX_MEMSZ:    strb.rdSel = SEL_MEMSZ;
      IDX_FROMHOST: strb.rdSel = SEL_FROMHOST;
      default:      strb.rdSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= anyAccess & ~permitted;
  end

endmodule

// File: rtl/sup_ctrl_regs_dp.sv
module sup_ctrl_regs_dp
  import sup_ctrl_regs_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              WORD_W     = 32,
  parameter int              ALIGN_BITS = 12,
  parameter logic [XLEN-1:0] MEM_BYTES  = 64'h0000_0000_1000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strb,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] fromHost,
  input  logic            trapCapture,
  input  logic [XLEN-1:0] trapAddr,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] toHost
);

  localparam logic [XLEN-1:0] MEM_PAGES  = MEM_BYTES >> ALIGN_BITS;
  localparam logic [XLEN-1:0] EBASE_KEEP = {XLEN{1'b1}} << ALIGN_BITS;
  localparam logic [XLEN-1:0] ALL_ONES   = {XLEN{1'b1}};

  logic [XLEN-1:0] statusQ, epcQ, badVaQ, ebaseQ, toHostQ;
  logic [XLEN-1:0] wrVal, rdMux, rdVal;

  always_comb begin
    case (strb.rdSel)
      SEL_STATUS:   rdMux = statusQ;
      SEL_EPC:      rdMux = epcQ;
      SEL_BADVA:    rdMux = badVaQ;
      SEL_EBASE:    rdMux = ebaseQ;
      SEL_MEMSZ:    rdMux = MEM_PAGES;
      SEL_FROMHOST: rdMux = fromHost;
      default:      rdMux = ALL_ONES;
    endcase
  end

  // Word-width sign extension exists only when the register is wider than a word
  generate
    if (XLEN > WORD_W) begin : g_narrow
      assign wrVal = strb.narrow
                   ? {{(XLEN-WORD_W){wrData[WORD_W-1]}}, wrData[WORD_W-1:0]}
                   : wrData;
      assign rdVal = strb.narrow
                   ? {{(XLEN-WORD_W){rdMux[WORD_W-1]}}, rdMux[WORD_W-1:0]}
                   : rdMux;
    end else begin : g_flat
      assign wrVal = wrData;
      assign rdVal = rdMux;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      epcQ    <= '0;
      badVaQ  <= '0;
      ebaseQ  <= '0;
      toHostQ <= '0;
      rdData  <= '0;
    end else begin
      if (strb.wrStatus) statusQ <= wrVal;
      if (strb.wrEpc)    epcQ    <= wrVal;
      if (strb.wrEbase)  ebaseQ  <= wrVal & EBASE_KEEP;
      if (strb.wrToHost) toHostQ <= wrVal;
      if (trapCapture)   badVaQ  <= trapAddr;
      if (strb.rdLoad)       rdData <= rdVal;
      else if (strb.rdClear) rdData <= '0;
    end
  end

  assign toHost = toHostQ;

endmodule

// File: rtl/sup_ctrl_regs.sv
module sup_ctrl_regs
  import sup_ctrl_regs_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              WORD_W     = 32,
  parameter int              ALIGN_BITS = 12,
  parameter logic [XLEN-1:0] MEM_BYTES  = 64'h0000_0000_1000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [4:0]      regIdx,
  input  logic            rdEn,
  input  logic            wrEn,
  input  logic            wordMode,
  input  logic            wide64Mode,
  input  logic            supMode,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] fromHost,
  input  logic            trapCapture,
  input  logic [XLEN-1:0] trapAddr,
  output logic [XLEN-1:0] rdData,
  output logic            privFault,
  output logic [XLEN-1:0] toHost
);

  strobes_t strb;

  sup_ctrl_regs_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regIdx     (regIdx),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .wordMode   (wordMode),
    .wide64Mode (wide64Mode),
    .supMode    (supMode),
    .strb       (strb),
    .privFault  (privFault)
  );

  sup_ctrl_regs_dp #(
    .XLEN       (XLEN),
    .WORD_W     (WORD_W),
    .ALIGN_BITS (ALIGN_BITS),
    .MEM_BYTES  (MEM_BYTES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .fromHost    (fromHost),
    .trapCapture (trapCapture),
    .trapAddr    (trapAddr),
    .rdData      (rdData),
    .toHost      (toHost)
  );

endmodule

// File: rtl/sup_ctrl_regs_chk.sv
module sup_ctrl_regs_chk #(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] MEM_BYTES = 64'h0000_0000_1000_0000
) (
  input logic            clk,
  input logic            rstN,
  input logic [4:0]      regIdx,
  input logic            rdEn,
  input logic            wrEn,
  input logic            wordMode,
  input logic            wide64Mode,
  input logic            supMode,
  input logic [XLEN-1:0] rdData,
  input logic            privFault,
  input logic [XLEN-1:0] toHost
);

  logic okAcc;
  assign okAcc = supMode & (wordMode | wide64Mode);

  // R7
  user_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn || wrEn) && !supMode |=> privFault);

  // R7
  fault_keeps_tohost_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !okAcc |=> $stable(toHost));

  // R7
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn || wrEn) |=> !privFault);

  // R10
  wide_needs_64_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wordMode && !wide64Mode |=> privFault && rdData == '0);

  // R6
  ebase_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && okAcc && regIdx == 5'd3 |=> rdData[11:0] == 12'd0);

  // R8
  word_read_sext_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && okAcc && wordMode |=> rdData[XLEN-1:32] == {(XLEN-32){rdData[31]}});

  // R3
  memsize_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && okAcc && !wordMode && regIdx == 5'd8 |=> rdData == (MEM_BYTES >> 12));

  // R4
  unmapped_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && okAcc && regIdx inside {5'd4, 5'd16, 5'd31} |=> rdData == {XLEN{1'b1}});

endmodule

bind sup_ctrl_regs sup_ctrl_regs_chk #(.XLEN(XLEN), .MEM_BYTES(MEM_BYTES)) chk_i (.*);

// File: tb/sup_ctrl_regs_tb.sv
module sup_ctrl_regs_tb_top;

  localparam logic [63:0] MEMB = 64'h0000_0000_1000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regIdx = '0;
  logic        rdEn = 0, wrEn = 0, wordMode = 0, wide64Mode = 1, supMode = 1;
  logic [63:0] wrData = '0, fromHost = '0, trapAddr = '0;
  logic        trapCapture = 0;
  logic [63:0] rdData, toHost;
  logic        privFault;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  sup_ctrl_regs #(.MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .rdEn(rdEn), .wrEn(wrEn),
    .wordMode(wordMode), .wide64Mode(wide64Mode), .supMode(supMode),
    .wrData(wrData), .fromHost(fromHost), .trapCapture(trapCapture),
    .trapAddr(trapAddr), .rdData(rdData), .privFault(privFault), .toHost(toHost)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One-cycle access driven on the falling edge; outputs valid at the next falling edge
  task automatic access(input logic [4:0] idx, input bit rd, input bit wr,
                        input logic [63:0] val, input bit word, input bit sup, input bit w64);
    @(negedge clk);
    regIdx = idx; rdEn = rd; wrEn = wr; wrData = val;
    wordMode = word; supMode = sup; wide64Mode = w64;
    @(negedge clk);
    rdEn = 0; wrEn = 0; wordMode = 0; supMode = 1; wide64Mode = 1;
  endtask

  task automatic rd64(input logic [4:0] idx);
    access(idx, 1, 0, '0, 0, 1, 1);
  endtask

  task automatic wr64(input logic [4:0] idx, input logic [63:0] val);
    access(idx, 0, 1, val, 0, 1, 1);
  endtask

  task automatic test_reset;
    check("R1 rdData", rdData, '0);
    check("R1 privFault", {63'd0, privFault}, '0);
    check("R1 toHost", toHost, '0);
    for (int i = 0; i < 4; i++) begin
      rd64(i[4:0]);
      check("R1 reg zero", rdData, '0);
    end
  endtask

  task automatic test_trap;
    @(negedge clk);
    trapAddr = 64'hDEAD_BEEF_0000_1234; trapCapture = 1; supMode = 0; wide64Mode = 0;
    @(negedge clk);
    trapCapture = 0; supMode = 1; wide64Mode = 1;
    rd64(5'd2);
    check("R11 trap capture", rdData, 64'hDEAD_BEEF_0000_1234);
  endtask

  task automatic test_readmap;
    wr64(5'd0, 64'h1111_2222_3333_4444);
    wr64(5'd1, 64'hAAAA_BBBB_CCCC_DDDD);
    rd64(5'd0); check("R2 R5 status", rdData, 64'h1111_2222_3333_4444);
    rd64(5'd1); check("R2 R5 epc", rdData, 64'hAAAA_BBBB_CCCC_DDDD);
    fromHost = 64'h0000_0077_0000_0099;
    rd64(5'd17); check("R2 fromHost", rdData, 64'h0000_0077_0000_0099);
  endtask

  task automatic test_ignored_writes;
    wr64(5'd2, 64'h0);
    rd64(5'd2); check("R5 write idx2 ignored", rdData, 64'hDEAD_BEEF_0000_1234);
    wr64(5'd17, 64'h5);
    rd64(5'd17); check("R5 write idx17 ignored", rdData, 64'h0000_0077_0000_0099);
    wr64(5'd9, 64'h0);
    rd64(5'd0); check("R5 write idx9 ignored", rdData, 64'h1111_2222_3333_4444);
    check("R5 toHost untouched", toHost, '0);
  endtask

  task automatic test_tohost;
    wr64(5'd16, 64'h0123_4567_89AB_CDEF);
    check("R12 toHost", toHost, 64'h0123_4567_89AB_CDEF);
    rd64(5'd16); check("R4 idx16 reads ones", rdData, ONES);
  endtask

  task automatic test_memsize;
    rd64(5'd8); check("R3 memsize", rdData, MEMB >> 12);
    access(5'd8, 1, 0, '0, 1, 1, 1); check("R3 memsize word", rdData, MEMB >> 12);
  endtask

  task automatic test_unassigned;
    rd64(5'd5);  check("R4 idx5", rdData, ONES);
    rd64(5'd31); check("R4 idx31", rdData, ONES);
    access(5'd4, 1, 0, '0, 1, 1, 1); check("R4 idx4 word", rdData, ONES);
  endtask

  task automatic test_ebase;
    wr64(5'd3, 64'h1234_5678_9ABC_DEF0);
    rd64(5'd3); check("R6 ebase mask", rdData, 64'h1234_5678_9ABC_D000);
    access(5'd3, 1, 0, '0, 1, 1, 1); check("R8 ebase word read", rdData, 64'hFFFF_FFFF_9ABC_D000);
    access(5'd3, 0, 1, 64'h0000_0000_8000_0FFF, 1, 1, 1);
    rd64(5'd3); check("R6 R9 ebase word write", rdData, 64'hFFFF_FFFF_8000_0000);
  endtask

  task automatic test_priv;
    access(5'd0, 0, 1, 64'h0, 0, 0, 1);
    check("R7 write fault flag", {63'd0, privFault}, 64'd1);
    access(5'd16, 0, 1, 64'h0, 0, 0, 1);
    check("R7 toHost unchanged", toHost, 64'h0123_4567_89AB_CDEF);
    rd64(5'd0); check("R7 status unchanged", rdData, 64'h1111_2222_3333_4444);
    check("R7 fault clears", {63'd0, privFault}, 64'd0);
    access(5'd0, 1, 0, '0, 0, 0, 1);
    check("R7 read fault data", rdData, '0);
    check("R7 read fault flag", {63'd0, privFault}, 64'd1);
  endtask

  task automatic test_word_read;
    access(5'd1, 1, 0, '0, 1, 1, 1); check("R8 epc word", rdData, 64'hFFFF_FFFF_CCCC_DDDD);
    access(5'd0, 1, 0, '0, 1, 1, 1); check("R8 status word", rdData, 64'h0000_0000_3333_4444);
  endtask

  task automatic test_word_write;
    access(5'd1, 0, 1, 64'h1234_5678_8000_0001, 1, 1, 1);
    rd64(5'd1); check("R9 epc word write", rdData, 64'hFFFF_FFFF_8000_0001);
    access(5'd16, 0, 1, 64'hFFFF_FFFF_7000_0000, 1, 1, 1);
    check("R9 toHost word write", toHost, 64'h0000_0000_7000_0000);
  endtask

  task automatic test_mode64;
    access(5'd1, 1, 0, '0, 0, 1, 0);
    check("R10 wide read fault", {63'd0, privFault}, 64'd1);
    check("R10 wide read data", rdData, '0);
    access(5'd16, 0, 1, 64'h5555_5555_5555_5555, 0, 1, 0);
    check("R10 wide write dropped", toHost, 64'h0000_0000_7000_0000);
    access(5'd1, 1, 0, '0, 1, 1, 0);
    check("R10 word ok flag", {63'd0, privFault}, 64'd0);
    check("R10 word ok data", rdData, 64'hFFFF_FFFF_8000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    test_reset;
    test_trap;
    test_readmap;
    test_ignored_writes;
    test_tohost;
    test_memsize;
    test_unassigned;
    test_ebase;
    test_priv;
    test_word_read;
    test_word_write;
    test_mode64;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule